// File: doc/BRIEF.md
# Quad Potentiometer Register Bank

This block holds the register state of four digitally controlled potentiometer channels and answers a byte-level slave interface. Each channel owns one volatile wiper register, whose value drives the channel's wiper position output, and four data registers that model nonvolatile storage. The data registers are grouped by index into four pages of four, and the wiper registers form a fifth page. A 3-bit select register, reached at byte address 07h, decides which page the channel addresses 00h to 03h reach.

The serial front end is not part of the block. It delivers already-framed events on `cmd_i`: a device-address event that opens a transaction, a byte-address event, a data write, a data read, and a STOP. Every event except STOP gets exactly one response one cycle later, carrying ACK or NACK and, for reads, the byte read. Any access to a data register also copies that byte into the same channel's wiper register. When a transaction that wrote at least one data register ends with STOP, the block enters a busy window of `BUSY_CYCLES` clocks. During that window it refuses every transaction, which lets the host poll until the write has finished.

Top module: `dpot_bank`

## Requirements
- R1: After reset the select register reads 00h, all wiper outputs are 00h, `busy_o` is 0 and `rsp_vld_o` is 0.
- R2: `cmd_i` codes are 0 device, 1 byte address, 2 write, 3 read, 4 STOP. Codes 0 to 3 produce exactly one response with `rsp_vld_o` high in the cycle after the command. STOP and the unused codes produce none.
- R3: A byte address below 04h selects channel 0 to 3 and one equal to 07h selects the select register, and both are ACKed. Any other address is NACKed and ends the transaction.
- R4: In the select register, bit 0 set to 0 routes channel accesses to the wiper page and set to 1 routes them to the data page numbered by bits 2:1. Bits 7:3 read back as 0 whatever was written.
- R5: A write to the wiper page changes that channel's wiper output on the clock edge that accepts it and never starts a busy window.
- R6: Each accepted data byte (read or write) on a channel address moves the channel index to the next channel, wrapping from 3 to 0. Accesses to address 07h leave the index unchanged.
- R7: A write to a data register stores the byte and also loads it into the same channel's wiper register.
- R8: A read of a data register returns the stored byte and loads it into the same channel's wiper register, without starting a busy window.
- R9: A STOP that closes a transaction containing a data-register write raises `busy_o` in the next cycle and holds it for exactly `BUSY_CYCLES` cycles.
- R10: While `busy_o` is 1, a device event is NACKed and no register or wiper output changes.
- R11: Byte-address, write and read events are ACKed only inside a transaction opened by an ACKed device event. Read events also need a valid byte address. Every NACK response carries data 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld_i | input | 1 | Event strobe, one cycle per event |
| cmd_i | input | 3 | Event code (see R2) |
| dat_i | input | DW | Byte address or write data |
| rsp_vld_o | output | 1 | Response valid |
| rsp_ack_o | output | 1 | 1 = ACK, 0 = NACK |
| rsp_dat_o | output | DW | Read data, 00h unless an ACKed read |
| busy_o | output | 1 | Write window in progress |
| wiper_o | output | NCH*DW | Wiper registers, channel c at bits c*DW +: DW |

## Verification
The bench builds the block with `BUSY_CYCLES` set to 20 and keeps the default four channels, 8-bit data and select address 07h. The short window lets the bench count the whole busy period edge by edge and probe it with refused transactions, then run a full second transaction after it, all within a few hundred cycles. Four channels make the index wrap from 3 to 0 reachable with a five-byte burst, and together with the wiper outputs this shows every copy from a data register into a wiper register.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   typedef enum logic [2:0] {
      EV_DEV  = 3'd0,
      EV_ADR  = 3'd1,
      EV_WR   = 3'd2,
      EV_RD   = 3'd3,
      EV_STOP = 3'd4
   } dpot_ev_e;

   localparam int unsigned SEL_BITS  = 3;
   localparam int unsigned DR_PAGES  = 4;

endpackage

// File: rtl/dpot_seq.sv
module dpot_seq #(
   parameter int unsigned NCH     = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned SR_ADDR = 7,
   localparam int unsigned CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_vld_i,
   input  logic [2:0]     cmd_i,
   input  logic [DW-1:0]  dat_i,
   input  logic           busy_i,
   input  logic           nv_sel_i,
   output logic           acc_o,
   output logic           rsp_o,
   output logic           wr_o,
   output logic           rd_o,
   output logic           sel_tgt_o,
   output logic [CHW-1:0] ch_o,
   output logic           nv_go_o
);
   import dpot_pkg::*;

   localparam logic [DW-1:0] SR_A  = DW'(SR_ADDR);
   localparam logic [DW-1:0] NCH_A = DW'(NCH);

   logic           open_q, adr_ok_q, sel_q, nvd_q;
   logic [CHW-1:0] ch_q;
   logic           adr_hit;
   dpot_ev_e       ev;

   assign ev      = dpot_ev_e'(cmd_i);
   assign adr_hit = (dat_i < NCH_A) || (dat_i == SR_A);

   always_comb begin
      acc_o = 1'b0;
      rsp_o = 1'b0;
      if (cmd_vld_i) begin
         case (ev)
            EV_DEV:  begin rsp_o = 1'b1; acc_o = !busy_i;            end
            EV_ADR:  begin rsp_o = 1'b1; acc_o = open_q && adr_hit;  end
            EV_WR,
            EV_RD:   begin rsp_o = 1'b1; acc_o = open_q && adr_ok_q; end
            default: begin rsp_o = 1'b0; acc_o = 1'b0;              end
         endcase
      end
   end

   assign wr_o      = cmd_vld_i && (ev == EV_WR) && acc_o;
   assign rd_o      = cmd_vld_i && (ev == EV_RD) && acc_o;
   assign nv_go_o   = cmd_vld_i && (ev == EV_STOP) && nvd_q;
   assign sel_tgt_o = sel_q;
   assign ch_o      = ch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         adr_ok_q <= 1'b0;
         sel_q    <= 1'b0;
         nvd_q    <= 1'b0;
         ch_q     <= '0;
      end else if (cmd_vld_i) begin
         case (ev)
            EV_DEV: begin
               open_q   <= !busy_i;
               adr_ok_q <= 1'b0;
            end
            EV_ADR: begin
               if (acc_o) begin
                  adr_ok_q <= 1'b1;
                  sel_q    <= (dat_i == SR_A);
                  ch_q     <= dat_i[CHW-1:0];
               end else begin
                  open_q   <= 1'b0;
                  adr_ok_q <= 1'b0;
               end
            end
            EV_WR, EV_RD: begin
               if (acc_o && !sel_q) begin
                  ch_q <= ch_q + CHW'(1);
                  if (ev == EV_WR && nv_sel_i)
                     nvd_q <= 1'b1;
               end
            end
            EV_STOP: begin
               open_q   <= 1'b0;
               adr_ok_q <= 1'b0;
               nvd_q    <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dpot_store.sv
module dpot_store #(
   parameter int unsigned NCH  = 4,
   parameter int unsigned DW   = 8,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned PG  = dpot_pkg::DR_PAGES,
   localparam int unsigned SB  = dpot_pkg::SEL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic              sel_tgt_i,
   input  logic [CHW-1:0]    ch_i,
   input  logic [DW-1:0]     dat_i,
   output logic [DW-1:0]     rdat_o,
   output logic              nv_sel_o,
   output logic [NCH*DW-1:0] wiper_o
);

   logic [SB-1:0]                  sel_q;
   logic [1:0]                     page;
   logic                           nv;
   logic [NCH-1:0][DW-1:0]         wcr_v;
   logic [PG-1:0][NCH-1:0][DW-1:0] dr_v;

   assign nv       = sel_q[0];
   assign page     = sel_q[2:1];
   assign nv_sel_o = nv;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_i && sel_tgt_i)
         sel_q <= dat_i[SB-1:0];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic          hit;
      logic [DW-1:0] wcr_q;

      assign hit = !sel_tgt_i && (ch_i == CHW'(c));

      always_ff @(posedge clk) begin
         if (!rst_n)
            wcr_q <= '0;
         else if (hit && wr_i)
            wcr_q <= dat_i;
         else if (hit && rd_i && nv)
            wcr_q <= dr_v[page][c];
      end

      assign wcr_v[c]             = wcr_q;
      assign wiper_o[c*DW +: DW]  = wcr_q;

      for (genvar p = 0; p < PG; p++) begin : g_pg
         logic [DW-1:0] dr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               dr_q <= '0;
            else if (hit && wr_i && nv && (page == 2'(p)))
               dr_q <= dat_i;
         end
         assign dr_v[p][c] = dr_q;
      end
   end

   always_comb begin
      if (sel_tgt_i)
         rdat_o = {{(DW-SB){1'b0}}, sel_q};
      else if (nv)
         rdat_o = dr_v[page][ch_i];
      else
         rdat_o = wcr_v[ch_i];
   end

endmodule

// File: rtl/dpot_busy.sv
module dpot_busy #(
   parameter int unsigned CYC = 500000,
   localparam int unsigned CW = $clog2(CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (go_i)
         cnt_q <= CW'(CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/dpot_bank.sv
module dpot_bank #(
   parameter int unsigned NCH         = 4,
   parameter int unsigned DW          = 8,
   parameter int unsigned BUSY_CYCLES = 500000,
   parameter int unsigned SR_ADDR     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld_i,
   input  logic [2:0]        cmd_i,
   input  logic [DW-1:0]     dat_i,
   output logic              rsp_vld_o,
   output logic              rsp_ack_o,
   output logic [DW-1:0]     rsp_dat_o,
   output logic              busy_o,
   output logic [NCH*DW-1:0] wiper_o
);

   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_chk_nch
      $error("dpot_bank: NCH must be a power of two of at least 2");
   end
   if (DW < dpot_pkg::SEL_BITS) begin : g_chk_dw
      $error("dpot_bank: DW too narrow for the select register");
   end
   if (SR_ADDR < NCH || SR_ADDR >= (1 << DW)) begin : g_chk_sr
      $error("dpot_bank: SR_ADDR must lie above the channel addresses and fit in DW");
   end
   if (BUSY_CYCLES < 1) begin : g_chk_busy
      $error("dpot_bank: BUSY_CYCLES must be at least 1");
   end

   logic           acc, rsp, wr, rd, sel_tgt, nv_go, nv_sel;
   logic [CHW-1:0] ch;
   logic [DW-1:0]  rdat;

   dpot_seq #(.NCH(NCH), .DW(DW), .SR_ADDR(SR_ADDR)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_vld_i (cmd_vld_i),
      .cmd_i     (cmd_i),
      .dat_i     (dat_i),
      .busy_i    (busy_o),
      .nv_sel_i  (nv_sel),
      .acc_o     (acc),
      .rsp_o     (rsp),
      .wr_o      (wr),
      .rd_o      (rd),
      .sel_tgt_o (sel_tgt),
      .ch_o      (ch),
      .nv_go_o   (nv_go)
   );

   dpot_store #(.NCH(NCH), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr),
      .rd_i      (rd),
      .sel_tgt_i (sel_tgt),
      .ch_i      (ch),
      .dat_i     (dat_i),
      .rdat_o    (rdat),
      .nv_sel_o  (nv_sel),
      .wiper_o   (wiper_o)
   );

   dpot_busy #(.CYC(BUSY_CYCLES)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (nv_go),
      .busy_o (busy_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld_o <= 1'b0;
         rsp_ack_o <= 1'b0;
         rsp_dat_o <= '0;
      end else begin
         rsp_vld_o <= rsp;
         rsp_ack_o <= rsp && acc;
         rsp_dat_o <= rd ? rdat : '0;
      end
   end

endmodule

// File: rtl/dpot_bank_chk.sv
module dpot_bank_chk #(
   parameter int unsigned NCH     = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned SR_ADDR = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_vld_i,
   input logic [2:0]        cmd_i,
   input logic [DW-1:0]     dat_i,
   input logic              rsp_vld_o,
   input logic              rsp_ack_o,
   input logic [DW-1:0]     rsp_dat_o,
   input logic              busy_o,
   input logic [NCH*DW-1:0] wiper_o
);

   localparam logic [DW-1:0] SR_A  = DW'(SR_ADDR);
   localparam logic [DW-1:0] NCH_A = DW'(NCH);

   a_r2_rsp_origin: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o |-> $past(cmd_vld_i && (cmd_i <= 3'd3)));

   a_r3_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_i && cmd_i == 3'd1 && dat_i >= NCH_A && dat_i != SR_A)
      |=> (rsp_vld_o && !rsp_ack_o));

   a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(cmd_vld_i && cmd_i == 3'd4));

   a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_i && cmd_i == 3'd0 && busy_o) |=> (rsp_vld_o && !rsp_ack_o));

   a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(wiper_o));

   a_r11_nack_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld_o && !rsp_ack_o) |-> (rsp_dat_o == '0));

endmodule

bind dpot_bank dpot_bank_chk #(.NCH(NCH), .DW(DW), .SR_ADDR(SR_ADDR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_vld_i (cmd_vld_i),
   .cmd_i     (cmd_i),
   .dat_i     (dat_i),
   .rsp_vld_o (rsp_vld_o),
   .rsp_ack_o (rsp_ack_o),
   .rsp_dat_o (rsp_dat_o),
   .busy_o    (busy_o),
   .wiper_o   (wiper_o)
);

// File: tb/dpot_bank_tb_top.sv
module dpot_bank_tb_top;

   localparam int unsigned NCH  = 4;
   localparam int unsigned DW   = 8;
   localparam int unsigned BUSY = 20;

   localparam logic [2:0] DEV = 3'd0, ADR = 3'd1, WR = 3'd2, RD = 3'd3, STP = 3'd4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_vld_i = 1'b0;
   logic [2:0]        cmd_i = 3'd0;
   logic [DW-1:0]     dat_i = '0;
   logic              rsp_vld_o, rsp_ack_o, busy_o;
   logic [DW-1:0]     rsp_dat_o;
   logic [NCH*DW-1:0] wiper_o;

   int n_run  = 0;
   int n_fail = 0;

   logic [DW:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   dpot_bank #(.NCH(NCH), .DW(DW), .BUSY_CYCLES(BUSY), .SR_ADDR(7)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_vld_i (cmd_vld_i),
      .cmd_i     (cmd_i),
      .dat_i     (dat_i),
      .rsp_vld_o (rsp_vld_o),
      .rsp_ack_o (rsp_ack_o),
      .rsp_dat_o (rsp_dat_o),
      .busy_o    (busy_o),
      .wiper_o   (wiper_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int wip(input int c);
      return int'(wiper_o[c*DW +: DW]);
   endfunction

   // monitor: pops one expected response per observed response
   always @(negedge clk) begin
      if (rst_n && rsp_vld_o) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected response", 1, 0);
         end else begin
            logic [DW:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, int'({rsp_ack_o, rsp_dat_o}), int'(e));
         end
      end
   end

   // driver: one event, expected response queued for the monitor
   task automatic op(input logic [2:0] c, input logic [7:0] d,
                     input logic a, input logic [7:0] ed, input string tag);
      @(negedge clk);
      cmd_vld_i = 1'b1;
      cmd_i     = c;
      dat_i     = d;
      if (c <= RD) begin
         exp_q.push_back({a, ed});
         tag_q.push_back(tag);
      end
      @(negedge clk);
      cmd_vld_i = 1'b0;
   endtask

   task automatic set_sel(input logic [7:0] v);
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h07, 1'b1, 8'h00, "R3 sel addr");
      op(WR,  v,     1'b1, 8'h00, "R4 sel write");
      op(STP, 8'h00, 1'b0, 8'h00, "");
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy after reset", int'(busy_o), 0);
      chk("R1 rsp_vld after reset", int'(rsp_vld_o), 0);
      for (int c = 0; c < NCH; c++) chk("R1 wiper reset", wip(c), 0);
      op(DEV, 8'h00, 1'b1, 8'h00, "R1 dev ack");
      op(ADR, 8'h07, 1'b1, 8'h00, "R3 sel addr ack");
      op(RD,  8'h00, 1'b1, 8'h00, "R1 sel reads 00");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R2 no response to STOP", int'(rsp_vld_o), 0);

      // R4 reserved bits, R6 index holds at select address
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h07, 1'b1, 8'h00, "R3 sel addr");
      op(WR,  8'hFF, 1'b1, 8'h00, "R4 sel write FF");
      op(RD,  8'h00, 1'b1, 8'h07, "R4 reserved read 0 / R6 sel index held");
      op(WR,  8'h00, 1'b1, 8'h00, "R4 sel write 00");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R5 no busy after sel writes", int'(busy_o), 0);

      // R5/R6 wiper page burst with wrap
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h02, 1'b1, 8'h00, "R3 ch2 addr");
      op(WR,  8'h11, 1'b1, 8'h00, "R5 wr");
      op(WR,  8'h22, 1'b1, 8'h00, "R5 wr");
      op(WR,  8'h33, 1'b1, 8'h00, "R6 wr wrap");
      op(WR,  8'h44, 1'b1, 8'h00, "R6 wr");
      op(WR,  8'h55, 1'b1, 8'h00, "R6 wr");
      chk("R6 wiper ch0", wip(0), 'h33);
      chk("R6 wiper ch1", wip(1), 'h44);
      chk("R6 wiper ch2 rewritten", wip(2), 'h55);
      chk("R5 wiper ch3", wip(3), 'h22);
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R5 no busy after wiper writes", int'(busy_o), 0);
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h01, 1'b1, 8'h00, "R3 ch1 addr");
      op(RD,  8'h00, 1'b1, 8'h44, "R6 read ch1");
      op(RD,  8'h00, 1'b1, 8'h55, "R6 read ch2 after increment");
      op(STP, 8'h00, 1'b0, 8'h00, "");

      // R7/R9 data page 1 write then busy window
      set_sel(8'h03);
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h00, 1'b1, 8'h00, "R3 ch0 addr");
      op(WR,  8'hA0, 1'b1, 8'h00, "R7 dr wr");
      op(WR,  8'hA1, 1'b1, 8'h00, "R7 dr wr");
      chk("R7 wiper ch0 loaded", wip(0), 'hA0);
      chk("R7 wiper ch1 loaded", wip(1), 'hA1);
      op(STP, 8'h00, 1'b0, 8'h00, "");
      n = 0;
      while (busy_o && n < 1000) begin n++; @(negedge clk); end
      chk("R9 busy window length", n, BUSY);

      // R10 refused while busy
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h02, 1'b1, 8'h00, "R3 ch2 addr");
      op(WR,  8'hB2, 1'b1, 8'h00, "R7 dr wr");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R9 busy rises after STOP", int'(busy_o), 1);
      op(DEV, 8'h00, 1'b0, 8'h00, "R10 dev nacked while busy");
      op(ADR, 8'h03, 1'b0, 8'h00, "R10 addr nacked while busy");
      op(WR,  8'hEE, 1'b0, 8'h00, "R10 write nacked while busy");
      chk("R10 wiper ch3 unchanged", wip(3), 'h22);
      chk("R10 wiper ch2 unchanged", wip(2), 'hB2);
      n = 0;
      while (busy_o && n < 1000) begin n++; @(negedge clk); end

      // R8 data read loads wiper
      set_sel(8'h00);
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev after busy");
      op(ADR, 8'h00, 1'b1, 8'h00, "R3 ch0 addr");
      op(WR,  8'h01, 1'b1, 8'h00, "R5 wr");
      op(WR,  8'h02, 1'b1, 8'h00, "R5 wr");
      op(WR,  8'h03, 1'b1, 8'h00, "R5 wr");
      op(WR,  8'h04, 1'b1, 8'h00, "R5 wr");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      set_sel(8'h03);
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h01, 1'b1, 8'h00, "R3 ch1 addr");
      op(RD,  8'h00, 1'b1, 8'hA1, "R8 dr read ch1");
      op(RD,  8'h00, 1'b1, 8'hB2, "R8 dr read ch2");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R8 wiper ch1 from dr", wip(1), 'hA1);
      chk("R8 wiper ch2 from dr", wip(2), 'hB2);
      chk("R8 wiper ch0 untouched", wip(0), 'h01);
      chk("R8 wiper ch3 untouched", wip(3), 'h04);
      chk("R8 no busy after reads", int'(busy_o), 0);

      // R4 page selection by bits 2:1
      set_sel(8'h05);
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h00, 1'b1, 8'h00, "R3 ch0 addr");
      op(RD,  8'h00, 1'b1, 8'h00, "R4 page2 ch0 empty");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R4 wiper ch0 loaded from page2", wip(0), 0);

      // R3/R11 refused accesses
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(ADR, 8'h05, 1'b0, 8'h00, "R3 bad address nacked");
      op(RD,  8'h00, 1'b0, 8'h00, "R3 read after bad address");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      op(WR,  8'h77, 1'b0, 8'h00, "R11 write without dev");
      op(RD,  8'h00, 1'b0, 8'h00, "R11 read without dev");
      op(DEV, 8'h00, 1'b1, 8'h00, "R11 dev");
      op(RD,  8'h00, 1'b0, 8'h00, "R11 read without address");
      op(STP, 8'h00, 1'b0, 8'h00, "");
      chk("R3 wiper ch1 unchanged", wip(1), 'hA1);
      chk("R2 no busy", int'(busy_o), 0);

      repeat (2) @(negedge clk);
      chk("R2 every response seen", exp_q.size(), 0);
      finish_run();
   end

endmodule